// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out one read or one write of a register inside an external PHY over the two-wire management interface (MDC clock plus bidirectional MDIO data). Software first sets the management enable and a clock-divider choice in a control register. It then writes a single 32-bit command word that packs the frame start, opcode, PHY address, register address, turnaround and 16-bit data field. That write alone launches the transaction.

The engine sends a 64-bit frame made of 32 preamble ones followed by the command word. Software waits for the idle bit in the status register to return high. For a read, the engine releases MDIO from the turnaround bits onward and samples the PHY's 16 data bits on rising MDC edges. It places them in the data field of the same command word, where software reads them back.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the status idle bit (status bit 0) reads 1, the control register reads 0, MDC is low and the MDIO output enable is low.
- R2: A write to the command register (address 2) while management is enabled (control bit 0 = 1) and the engine is idle starts a frame; a status read sampled on the next clock edge returns idle = 0.
- R3: Each frame carries 32 ones and then command bits 31 down to 0, MSB first. Each bit is set up while MDC is low and is held across the following rising MDC edge.
- R4: The MDC period in system clocks is 8, 16, 32 or 64 for control bits 2:1 equal to 0, 1, 2 or 3. MDC stays low whenever no frame is in progress.
- R5: A command whose opcode bits 29:28 equal 10 is a read. The output enable is low for frame bits 46 to 63 (the turnaround and data bits). The 16 bits sampled on the last 16 rising MDC edges replace command bits 15:0, first sample in bit 15, and bits 31:16 are kept.
- R6: A frame lasts exactly 64 MDC periods: idle is still 0 at the clock edge 64 x period after the starting edge and reads 1 one edge later.
- R7: A command write while a frame is in progress is ignored: the command register keeps its value and the frame on the wire is unchanged.
- R8: With control bit 0 low, a command write starts no frame and leaves the command register unchanged. Clearing the bit during a frame freezes MDC and MDIO until it is set again, after which the frame completes intact.
- R9: Register map: address 0 control, address 1 status, address 2 command, address 3 reads 0. Read data appears on the bus one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable (1 = engine drives) |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The bench uses the default parameters: a 2-bit divider select and a smallest divide of 8. All four MDC ratios, 8 to 64, are therefore reachable in a few thousand cycles each. The exact frame length and rising-edge spacing can be checked at every ratio, and a whole 64-bit frame can be captured on each of them. The bench acts as a small PHY model that drives read data only in the data window. This exercises sampling on the rising edges and write-back into the low half of the command word.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_IDX     = PRE_BITS + 14;
  localparam int RD_IDX     = PRE_BITS + 16;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0]  sof;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  ta;
    logic [15:0] data;
  } cmd_word_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CNT_W = MIN_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shamt;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  always_comb begin
    shamt   = CNT_W'(sel) + CNT_W'(MIN_LOG2 - 1);
    half_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
    tick    = run && (cnt == half_m1);
  end

  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [31:0]          word,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_in,
  output logic                 busy,
  output logic                 mdo,
  output logic                 oe,
  output logic                 frame_end,
  output logic                 rd_op,
  output logic [DATA_BITS-1:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  cmd_word_t             cw;
  logic [FRAME_BITS-1:0] frame_sh;
  logic [IDX_W-1:0]      bit_idx;

  assign cw        = cmd_word_t'(word);
  assign frame_end = busy && fall_tick && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mdo      <= 1'b0;
      oe       <= 1'b0;
      rd_op    <= 1'b0;
      bit_idx  <= '0;
      frame_sh <= '0;
      rd_data  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        frame_sh <= {{PRE_BITS{1'b1}}, word};
        bit_idx  <= '0;
        rd_op    <= (cw.op == OP_RD);
        mdo      <= 1'b1;
        oe       <= 1'b1;
      end
    end else begin
      if (rise_tick && rd_op && (bit_idx >= IDX_W'(RD_IDX)))
        rd_data <= {rd_data[DATA_BITS-2:0], mdio_in};
      if (fall_tick) begin
        if (bit_idx == LAST) begin
          busy <= 1'b0;
          oe   <= 1'b0;
          mdo  <= 1'b0;
        end else begin
          bit_idx  <= bit_idx + IDX_W'(1);
          frame_sh <= {frame_sh[FRAME_BITS-2:0], 1'b0};
          mdo      <= frame_sh[FRAME_BITS-2];
          oe       <= !(rd_op && (bit_idx >= IDX_W'(TA_IDX - 1)));
        end
      end
    end
  end

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_op && (bit_idx >= IDX_W'(TA_IDX))) |-> !oe); // R5
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !oe); // R6
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_eng_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 busy,
  input  logic                 frame_end,
  input  logic                 rd_op,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic                 mgmt_en,
  output logic [SEL_W-1:0]     div_sel,
  output logic                 start,
  output logic [31:0]          cmd_word
);
  reg_sel_e sel;
  logic     wr_ctrl;
  logic     wr_cmd;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_cmd  = bus_wr && (sel == SEL_CMD);
  assign start   = wr_cmd && mgmt_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_en  <= 1'b0;
      div_sel  <= '0;
      cmd_word <= '0;
    end else begin
      if (wr_ctrl) begin
        mgmt_en <= bus_wdata[0];
        div_sel <= bus_wdata[SEL_W:1];
      end
      if (start)
        cmd_word <= bus_wdata;
      else if (frame_end && rd_op)
        cmd_word[DATA_BITS-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL: bus_rdata <= 32'({div_sel, mgmt_en});
        SEL_STAT: bus_rdata <= {31'b0, ~busy};
        SEL_CMD:  bus_rdata <= cmd_word;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R2
  AST_BUSY_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && busy) |=> (cmd_word[31:16] == $past(cmd_word[31:16]))); // R7
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    !mgmt_en |-> !start); // R8
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_SEL_W    = 2,
  parameter int DIV_MIN_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic                 mgmt_en;
  logic [DIV_SEL_W-1:0] div_sel;
  logic                 start;
  logic [31:0]          cmd_word;
  logic                 busy;
  logic                 frame_end;
  logic                 rd_op;
  logic [DATA_BITS-1:0] rd_data;
  logic                 rise_tick;
  logic                 fall_tick;

  mdio_regs #(.SEL_W(DIV_SEL_W)) i_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .frame_end(frame_end), .rd_op(rd_op), .rd_data(rd_data),
    .mgmt_en(mgmt_en), .div_sel(div_sel), .start(start), .cmd_word(cmd_word)
  );

  mdio_mdc_gen #(.SEL_W(DIV_SEL_W), .MIN_LOG2(DIV_MIN_LOG2)) i_mdc (
    .clk(clk), .rst(rst),
    .run(busy && mgmt_en), .active(busy), .sel(div_sel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shift i_shift (
    .clk(clk), .rst(rst),
    .start(start), .word(bus_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_in),
    .busy(busy), .mdo(mdio_out), .oe(mdio_oe),
    .frame_end(frame_end), .rd_op(rd_op), .rd_data(rd_data)
  );

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R4
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && !mgmt_en && $past(busy && !mgmt_en)) |-> ($stable(mdc) && $stable(mdio_out))); // R8
endmodule

// File: tb/test_mdio_frame_engine.sv
`timescale 1ns/1ps
module test_mdio_frame_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b0;

  always #10 clk = ~clk;

  mdio_frame_engine i_mdio_frame_engine (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int checks = 0;
  int errors = 0;

  // Each entry: {divider select[1:0], command word[31:0], PHY reply[15:0]}
  localparam logic [49:0] VECS [5] = '{
    {2'd0, {2'b01, 2'b01, 5'd3,  5'd0,  2'b10, 16'hA5C3}, 16'h0000},
    {2'd1, {2'b01, 2'b10, 5'd31, 5'd1,  2'b10, 16'h1234}, 16'h796D},
    {2'd2, {2'b01, 2'b10, 5'd0,  5'd31, 2'b10, 16'h0000}, 16'h8001},
    {2'd3, {2'b01, 2'b01, 5'd21, 5'd10, 2'b10, 16'h0F0F}, 16'h0000},
    {2'd0, {2'b01, 2'b10, 5'd10, 5'd21, 2'b10, 16'hFFFF}, 16'h0000}
  };

  // PHY-side monitor
  int unsigned rises_tot = 0;
  int unsigned base = 0;
  int unsigned cyc = 0;
  int unsigned t0 = 0, t1 = 0;
  logic        prev_mdc = 1'b0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] phy_data = '0;

  always @(negedge clk) begin
    int unsigned idx;
    cyc++;
    if (mdc && !prev_mdc) begin
      idx = rises_tot - base;
      if (idx < 64) begin
        cap[63-idx]   = mdio_out;
        oecap[63-idx] = mdio_oe;
        if (idx == 0) t0 = cyc;
        if (idx == 1) t1 = cyc;
      end
      rises_tot++;
    end
    if (!mdc && prev_mdc) begin
      idx = rises_tot - base;
      mdio_in = (idx >= 48 && idx < 64) ? phy_data[63-idx] : 1'b0;
    end
    prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(2'd1, s);
      if (s[0]) break;
    end
  endtask

  function automatic logic [63:0] exp_oe(input logic [31:0] c);
    logic [63:0] e = '1;
    if (c[29:28] == 2'b10) e[17:0] = '0;
    return e;
  endfunction

  task automatic run_vec(input logic [1:0] sel, input logic [31:0] cmd, input logic [15:0] pd);
    logic [31:0] s;
    int unsigned div;
    bit rd;
    div = 8 << sel;
    rd  = (cmd[29:28] == 2'b10);
    bus_write(2'd0, {29'd0, sel, 1'b1});
    phy_data = pd;
    base = rises_tot;
    bus_write(2'd2, cmd);
    bus_read(2'd1, s);
    chk(s[0] == 1'b0, "R2 busy after start", 64'(s), 64'd0);
    repeat (64*div - 2) @(negedge clk);
    bus_read(2'd1, s);
    chk(s[0] == 1'b0, "R6 still busy at last edge", 64'(s), 64'd0);
    bus_read(2'd1, s);
    chk(s[0] == 1'b1, "R6 idle one edge later", 64'(s), 64'd1);
    chk((rises_tot - base) == 64, "R6 rising edge count", 64'(rises_tot - base), 64'd64);
    chk(mdc == 1'b0, "R4 mdc low after frame", 64'(mdc), 64'd0);
    chk((t1 - t0) == div, "R4 mdc period", 64'(t1 - t0), 64'(div));
    if (rd) begin
      chk(cap[63:18] == {32'hFFFF_FFFF, cmd[31:18]}, "R3 read frame header",
          64'(cap[63:18]), 64'({32'hFFFF_FFFF, cmd[31:18]}));
      chk(oecap == exp_oe(cmd), "R5 output enable window", oecap, exp_oe(cmd));
      bus_read(2'd2, s);
      chk(s == {cmd[31:16], pd}, "R5 read data write-back", 64'(s), 64'({cmd[31:16], pd}));
    end else begin
      chk(cap == {32'hFFFF_FFFF, cmd}, "R3 write frame bits", cap, {32'hFFFF_FFFF, cmd});
      chk(oecap == '1, "R3 driven through write", oecap, '1);
      bus_read(2'd2, s);
      chk(s == cmd, "R9 command readback", 64'(s), 64'(cmd));
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [31:0] ca, cb;
    logic        m, o;
    int unsigned r;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", 64'({mdc, mdio_oe}), 64'd0);
    bus_read(2'd1, s);
    chk(s == 32'd1, "R1 idle after reset", 64'(s), 64'd1);
    bus_read(2'd0, s);
    chk(s == 32'd0, "R1 control after reset", 64'(s), 64'd0);

    // Vector table
    for (int v = 0; v < 5; v++)
      run_vec(VECS[v][49:48], VECS[v][47:16], VECS[v][15:0]);

    // R9 register map
    bus_write(2'd0, 32'h0000_0005);
    bus_read(2'd0, s);
    chk(s == 32'd5, "R9 control readback", 64'(s), 64'd5);
    bus_read(2'd3, s);
    chk(s == 32'd0, "R9 unused address", 64'(s), 64'd0);

    // R7 write during frame ignored
    ca = {2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h3C5A};
    cb = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'hFFFF};
    bus_write(2'd0, 32'd1);
    base = rises_tot;
    bus_write(2'd2, ca);
    repeat (20) @(negedge clk);
    bus_write(2'd2, cb);
    bus_read(2'd2, s);
    chk(s == ca, "R7 command held while busy", 64'(s), 64'(ca));
    wait_idle();
    chk(cap == {32'hFFFF_FFFF, ca}, "R7 frame unaffected", cap, {32'hFFFF_FFFF, ca});

    // R8 pause mid-frame
    ca = {2'b01, 2'b01, 5'd18, 5'd4, 2'b10, 16'hC0DE};
    base = rises_tot;
    bus_write(2'd2, ca);
    repeat (100) @(negedge clk);
    bus_write(2'd0, 32'd0);
    m = mdc; o = mdio_out; r = rises_tot;
    repeat (60) @(negedge clk);
    chk(mdc == m && mdio_out == o && rises_tot == r, "R8 frozen while disabled",
        64'({mdc, mdio_out, 32'(rises_tot)}), 64'({m, o, 32'(r)}));
    bus_read(2'd1, s);
    chk(s[0] == 1'b0, "R8 still busy while paused", 64'(s), 64'd0);
    bus_write(2'd0, 32'd1);
    wait_idle();
    chk(cap == {32'hFFFF_FFFF, ca}, "R8 resumed frame intact", cap, {32'hFFFF_FFFF, ca});

    // R8 command write while disabled
    bus_write(2'd0, 32'd0);
    r = rises_tot;
    bus_write(2'd2, cb);
    bus_read(2'd1, s);
    chk(s[0] == 1'b1, "R8 no frame when disabled", 64'(s), 64'd1);
    repeat (100) @(negedge clk);
    chk(rises_tot == r, "R8 no mdc activity when disabled", 64'(rises_tot), 64'(r));
    bus_read(2'd2, s);
    chk(s == ca, "R8 command unchanged when disabled", 64'(s), 64'(ca));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule